// File: doc/BRIEF.md
# On-Screen Display Register Write Buffer

This block is the processor-facing register front end of an on-screen display engine. Software writes a display word into a small byte-wide buffer and then hands it to the display RAM side through a valid/ready stream. A status/control register reports whether the buffer can take a new word, and holds the end-of-display event flag with its interrupt enable. It also holds the pixel-clock half-rate select and the two-bit pixel-clock phase select, which go straight out to the display timing logic.

The word is committed by the write to the low byte. Higher bytes may be written beforehand in any order, and they keep their values from one word to the next. Between the commit and the RAM side's acceptance the buffer is busy: the ready bit reads 0 and further data writes are dropped. The stream obeys ordinary back-pressure rules. Once `xfer_valid` rises it stays high and `xfer_data` stays unchanged until a cycle in which `xfer_ready` is also high. That cycle is the transfer, and the buffer becomes free in the next cycle. `xfer_ready` has no effect while `xfer_valid` is low.

Top module: `osd_wbuf_regs`

## Requirements
- R1: After reset the status ready bit reads 1, the interrupt enable, half-rate, phase and end-of-display bits read 0, and `irq`, `xfer_valid`, `pix_half` and `pix_phase` are 0.
- R2: The address map is as follows. 0x61 is the status/control register. 0x62 is the low data byte and 0x63 is the high data byte, and both read back their buffered values. Any other address reads 0. In the status register, bit 7 is ready (read-only), bit 4 is end-of-display, bit 3 is interrupt enable, bit 2 is half-rate, and bits 1:0 are phase. Bits 6:5 read 0.
- R3: A write to 0x62 while the buffer is free clears the ready bit. From the next cycle it drives `xfer_valid` high with `xfer_data` = {high byte, low byte}, using the bytes last written.
- R4: While `xfer_valid` is high and `xfer_ready` is low, `xfer_valid` stays high and `xfer_data` is unchanged. After a cycle with both high, `xfer_valid` is low and the ready bit reads 1.
- R5: While the buffer is busy, writes to 0x62 and 0x63 are ignored, and both bytes read back unchanged.
- R6: The high byte may be written before the low byte or not at all. An unwritten high byte keeps its previous value in the next transfer.
- R7: A one-cycle `frame_end` pulse sets the end-of-display bit. Writing 1 to status bit 4 clears it. Writing 0 there leaves it unchanged. A pulse and a clearing write in the same cycle leave it set.
- R8: `irq` is high exactly when both the end-of-display bit and the interrupt enable bit are 1.
- R9: A status write sets `pix_half` from bit 2 and `pix_phase` from bits 1:0 (phase values 0 to 3), starting the next cycle. Writing bit 7 does not change the ready bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 8 | Register byte address |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr` (combinational) |
| frame_end | input | 1 | End-of-display event pulse from display logic |
| xfer_valid | output | 1 | Buffered word offered to display RAM |
| xfer_ready | input | 1 | Display RAM accepts the word |
| xfer_data | output | 16 | Buffered word, high byte in bits 15:8 |
| irq | output | 1 | Interrupt request |
| pix_half | output | 1 | 1: display clock is pixel clock divided by two |
| pix_phase | output | 2 | Pixel-clock phase adjustment select |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, two buffer lanes at 0x62 and 0x63, and the status register at 0x61. This gives a 16-bit transfer word in which the two bytes carry distinct patterns, so a swapped or stale lane shows up in `xfer_data`. The two-lane default also brings within reach the ordering cases the block depends on: the high byte written before the low byte, the high byte carried over from the previous word, and data writes dropped while a transfer is held back by the RAM side.

// File: rtl/osd_wbuf_pkg.sv
package osd_wbuf_pkg;
  // status/control register bit positions
  localparam int unsigned ST_READY = 7;
  localparam int unsigned ST_DONE  = 4;
  localparam int unsigned ST_IEN   = 3;
  localparam int unsigned ST_HALF  = 2;
  localparam int unsigned ST_PH_LO = 0;
  localparam int unsigned PH_W     = 2;
  localparam int unsigned REG_W    = 8;

  typedef struct packed {
    logic       irq_en;
    logic       half;
    logic [PH_W-1:0] phase;
  } osd_ctl_t;
endpackage

// File: rtl/osd_addr_dec.sv
module osd_addr_dec #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned LANES     = 2,
  parameter logic [7:0]  STAT_ADDR = 8'h61,
  parameter logic [7:0]  DATA_BASE = 8'h62
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              stat_hit,
  output logic [LANES-1:0]  lane_hit
);
  assign stat_hit = (addr == ADDR_W'(STAT_ADDR));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(DATA_BASE) + ADDR_W'(g);
    assign lane_hit[g] = (addr == LANE_ADDR);
  end
endmodule

// File: rtl/osd_data_buf.sv
module osd_data_buf #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned WORD_W = DATA_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_hit,
  output logic              busy,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [WORD_W-1:0] xfer_data
);
  logic pending;
  logic commit;
  logic accept;

  // lane 0 (low byte) commits the word; all lanes are locked while pending
  assign commit = wr_en && lane_hit[0] && !pending;
  assign accept = pending && xfer_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_byte
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q <= '0;
      else if (wr_en && lane_hit[g] && !pending) q <= wdata;
    end
    assign xfer_data[g*DATA_W +: DATA_W] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pending <= 1'b0;
    else if (commit) pending <= 1'b1;
    else if (accept) pending <= 1'b0;
  end

  assign busy       = pending;
  assign xfer_valid = pending;

  AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lane_hit[0] && !xfer_valid) |=> xfer_valid); // R3
  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_data))); // R4
  AST_ACCEPT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready) |=> !xfer_valid); // R4
  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(xfer_data)); // R5
endmodule

// File: rtl/osd_ctl_stat.sv
module osd_ctl_stat
  import osd_wbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             stat_hit,
  input  logic [REG_W-1:0] wdata,
  input  logic             frame_end,
  output osd_ctl_t         ctl,
  output logic             done_flag,
  output logic             irq
);
  logic stat_wr;
  assign stat_wr = wr_en && stat_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (stat_wr) begin
      ctl.irq_en <= wdata[ST_IEN];
      ctl.half   <= wdata[ST_HALF];
      ctl.phase  <= wdata[ST_PH_LO +: PH_W];
    end
  end

  // event flag: set by pulse, write-one-to-clear, set has priority
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          done_flag <= 1'b0;
    else if (frame_end)                  done_flag <= 1'b1;
    else if (stat_wr && wdata[ST_DONE])  done_flag <= 1'b0;
  end

  assign irq = done_flag && ctl.irq_en;

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> done_flag); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.irq_en |-> !irq); // R8
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !wdata[ST_DONE] && done_flag) |=> done_flag); // R7
  AST_CTRL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (ctl.phase == $past(wdata[ST_PH_LO +: PH_W]))); // R9
endmodule

// File: rtl/osd_wbuf_regs.sv
module osd_wbuf_regs
  import osd_wbuf_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LANES     = 2,
  parameter logic [7:0]  STAT_ADDR = 8'h61,
  parameter logic [7:0]  DATA_BASE = 8'h62,
  localparam int unsigned WORD_W   = DATA_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              frame_end,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [WORD_W-1:0] xfer_data,
  output logic              irq,
  output logic              pix_half,
  output logic [PH_W-1:0]   pix_phase
);
  logic             stat_hit;
  logic [LANES-1:0] lane_hit;
  logic             busy;
  logic             done_flag;
  osd_ctl_t         ctl;
  logic [REG_W-1:0] stat_val;

  osd_addr_dec #(
    .ADDR_W(ADDR_W), .LANES(LANES),
    .STAT_ADDR(STAT_ADDR), .DATA_BASE(DATA_BASE)
  ) u_dec (
    .addr(cpu_addr), .stat_hit(stat_hit), .lane_hit(lane_hit)
  );

  osd_data_buf #(.DATA_W(DATA_W), .LANES(LANES)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .wdata(cpu_wdata),
    .lane_hit(lane_hit), .busy(busy),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_data(xfer_data)
  );

  osd_ctl_stat u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .stat_hit(stat_hit),
    .wdata(cpu_wdata[REG_W-1:0]), .frame_end(frame_end),
    .ctl(ctl), .done_flag(done_flag), .irq(irq)
  );

  assign pix_half  = ctl.half;
  assign pix_phase = ctl.phase;

  always_comb begin
    stat_val                     = '0;
    stat_val[ST_READY]           = !busy;
    stat_val[ST_DONE]            = done_flag;
    stat_val[ST_IEN]             = ctl.irq_en;
    stat_val[ST_HALF]            = ctl.half;
    stat_val[ST_PH_LO +: PH_W]   = ctl.phase;
  end

  always_comb begin
    cpu_rdata = '0;
    if (stat_hit) cpu_rdata[REG_W-1:0] = stat_val;
    for (int i = 0; i < int'(LANES); i++) begin
      if (lane_hit[i]) cpu_rdata = xfer_data[i*DATA_W +: DATA_W];
    end
  end

  AST_READY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_hit && xfer_valid) |-> !cpu_rdata[ST_READY]); // R2
endmodule

// File: tb/osd_wbuf_regs_tb.sv
module osd_wbuf_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        frame_end = 1'b0;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [15:0] xfer_data;
  logic        irq;
  logic        pix_half;
  logic [1:0]  pix_phase;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  osd_wbuf_regs u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .frame_end(frame_end),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_data(xfer_data),
    .irq(irq), .pix_half(pix_half), .pix_phase(pix_phase)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(8'h61, v);
    check("R1", "status after reset", v, 8'h80);
    check("R1", "irq/valid/half/phase", {irq, xfer_valid, pix_half, pix_phase}, 0);
    rd(8'h40, v);
    check("R2", "unmapped address reads 0", v, 0);
  endtask

  task automatic t_transfer();
    logic [7:0] v;
    wr(8'h63, 8'hAB);
    check("R3", "no offer after high byte", xfer_valid, 0);
    wr(8'h62, 8'hCD);
    check("R3", "offer after low byte", xfer_valid, 1);
    check("R3", "offered word", xfer_data, 16'hABCD);
    rd(8'h61, v);
    check("R3", "ready bit busy", v[7], 0);
    repeat (3) @(negedge clk);
    check("R4", "offer held under back-pressure", xfer_valid, 1);
    check("R4", "word stable under back-pressure", xfer_data, 16'hABCD);
    wr(8'h62, 8'h11);
    wr(8'h63, 8'h22);
    rd(8'h62, v);
    check("R5", "low byte unchanged while busy", v, 8'hCD);
    rd(8'h63, v);
    check("R5", "high byte unchanged while busy", v, 8'hAB);
    check("R5", "offered word unchanged while busy", xfer_data, 16'hABCD);
    @(negedge clk); xfer_ready = 1'b1;
    @(negedge clk); xfer_ready = 1'b0;
    check("R4", "offer drops after accept", xfer_valid, 0);
    rd(8'h61, v);
    check("R4", "ready bit back", v[7], 1);
  endtask

  task automatic t_order();
    wr(8'h62, 8'h55);
    check("R6", "high byte carried over", xfer_data, 16'hAB55);
    @(negedge clk); xfer_ready = 1'b1;
    @(negedge clk); xfer_ready = 1'b0;
    wr(8'h63, 8'h3C);
    wr(8'h63, 8'hC3);
    wr(8'h62, 8'h5A);
    check("R6", "last high byte written wins", xfer_data, 16'hC35A);
    @(negedge clk); xfer_ready = 1'b1;
    @(negedge clk); xfer_ready = 1'b0;
    check("R4", "second accept frees buffer", xfer_valid, 0);
  endtask

  task automatic t_event();
    logic [7:0] v;
    wr(8'h61, 8'h00);
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    rd(8'h61, v);
    check("R7", "event bit set by pulse", v[4], 1);
    check("R8", "irq masked when disabled", irq, 0);
    wr(8'h61, 8'h08);
    check("R8", "irq with enable", irq, 1);
    rd(8'h61, v);
    check("R7", "writing 0 keeps event", v[4], 1);
    wr(8'h61, 8'h18);
    rd(8'h61, v);
    check("R7", "write 1 clears event", v[4], 0);
    check("R8", "irq drops after clear", irq, 0);
    @(negedge clk);
    cpu_addr = 8'h61; cpu_wdata = 8'h18; cpu_wr = 1'b1; frame_end = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; frame_end = 1'b0;
    rd(8'h61, v);
    check("R7", "pulse beats clear", v[4], 1);
    check("R8", "irq after set-wins", irq, 1);
    wr(8'h61, 8'h10);
    check("R8", "irq off with enable cleared", irq, 0);
  endtask

  task automatic t_clock_ctl();
    logic [7:0] v;
    wr(8'h61, 8'h06);
    check("R9", "half-rate out", pix_half, 1);
    check("R9", "phase out", pix_phase, 2);
    rd(8'h61, v);
    check("R2", "status layout", v, 8'h86);
    wr(8'h61, 8'h03);
    check("R9", "phase 3 full rate", {pix_half, pix_phase}, 3'b011);
    wr(8'h61, 8'hE0);
    rd(8'h61, v);
    check("R9", "bit 7 write ignored, bits 6:5 read 0", v, 8'h80);
    check("R9", "controls cleared", {pix_half, pix_phase}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_transfer();
    t_order();
    t_event();
    t_clock_ctl();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule